// File: doc/BRIEF.md
# Configurable Output Logic Macrocell Bank

This block models the output cells of a sum-of-products programmable logic array. Each cell receives a sum term from the AND/OR array and a dedicated output-enable product term. From these it produces a pin value, a pin enable and a feedback pair (true and complement) that returns to the array. Two configuration bits per cell set the behaviour. One bit chooses between a clocked path, built on a D flip-flop that captures the sum term, and a direct combinational path. The other bit chooses the output polarity.

All cells in the bank share one clock, one asynchronous clear term, one synchronous set term and a test preload strobe. Asynchronous clear, synchronous set and preload all act on the flip-flop state and not on the pin, so the pin level after a clear depends on the polarity chosen. The pin is modelled as three signals: the value driven out, its enable, and the level seen from outside.

A synchronous power-up reset clears every flip-flop. Preload lets a test sequencer force any state into the flip-flops, so that illegal state-machine states can be reached and their recovery checked.

Top module: `olmc_bank`

## Requirements
- R1: With the path bit `cfg_comb`=0 (clocked), `pin_out` equals the flip-flop state when `cfg_pol`=1 (active high) and its inverse when `cfg_pol`=0 (active low); on each rising clock edge with no clear, set, preload or reset, the flip-flop takes `sum_in`.
- R2: In clocked mode `fb_true` carries the inverted flip-flop state and `fb_comp` the flip-flop state, whatever `pin_in` does.
- R3: With `cfg_comb`=1, `pin_out` equals `sum_in` at once when `cfg_pol`=1 and its inverse when `cfg_pol`=0.
- R4: In combinational mode, `fb_true` equals `pin_out` while `oe_term` is 1 and equals `pin_in` while `oe_term` is 0.
- R5: `pin_oe` follows `oe_term` for each cell in both modes, so the term can hold a cell as an output, as an input, or switch it.
- R6: While `ar_term` is 1, every flip-flop reads 0 without waiting for a clock edge.
- R7: `sp_term`=1 sets every flip-flop to 1 on the next rising clock edge.
- R8: When `ar_term` and `sp_term` are both 1, the flip-flops stay at 0.
- R9: When `sp_term`=1, the flip-flop ignores `sum_in` on that edge.
- R10: With `pl_en`=1, each flip-flop loads its bit of `pl_val` on the rising edge, overriding both `sum_in` and `sp_term`.
- R11: `rst`=1 clears every flip-flop on the rising edge, overriding preload, set and data.
- R12: After a clear, a clocked cell drives `pin_out`=0 if active high and `pin_out`=1 if active low.
- R13: `fb_comp` is always the inverse of `fb_true`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flip-flops |
| rst | input | 1 | Synchronous active-high power-up clear |
| cfg_pol | input | CELLS | Polarity per cell, 1 = active high |
| cfg_comb | input | CELLS | Path per cell, 1 = combinational, 0 = clocked |
| sum_in | input | CELLS | Sum term per cell from the array |
| oe_term | input | CELLS | Output-enable product term per cell |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | CELLS | Preload value per cell |
| pin_in | input | CELLS | Level driven onto each pin from outside |
| pin_out | output | CELLS | Value driven onto each pin |
| pin_oe | output | CELLS | Pin driver enable |
| fb_true | output | CELLS | Feedback to the array, true form |
| fb_comp | output | CELLS | Feedback to the array, complement form |

## Verification
The shared set term can fall in the same cycle as either the asynchronous clear or the preload strobe. The bench provokes both collisions with `sum_in` held at the opposite value, and with differing preload bits per cell. A correct design leaves all-zero after clear plus set, and the preload pattern after preload plus set. A clear raised mid-cycle is judged before the next edge, to show that it does not wait for the clock.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef enum logic {
    PATH_CLOCKED = 1'b0,
    PATH_DIRECT  = 1'b1
  } path_e;

  typedef struct packed {
    logic level;
    logic enable;
  } drive_t;

endpackage

// File: rtl/olmc_store.sv
module olmc_store (
  input  logic clk,
  input  logic rst,
  input  logic clr_async,
  input  logic set_sync,
  input  logic ld_en,
  input  logic ld_val,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)
      q <= 1'b0;
    else if (rst)
      q <= 1'b0;
    else if (ld_en)
      q <= ld_val;
    else if (set_sync)
      q <= 1'b1;
    else
      q <= d;
  end

endmodule

// File: rtl/olmc_drive.sv
module olmc_drive
  import olmc_pkg::*;
(
  input  path_e  path,
  input  logic   pol_hi,
  input  logic   q,
  input  logic   sum,
  input  logic   oe_term,
  output drive_t drv
);

  logic raw;

  always_comb begin
    raw        = (path == PATH_CLOCKED) ? q : sum;
    drv.level  = pol_hi ? raw : ~raw;
    drv.enable = oe_term;
  end

endmodule

// File: rtl/olmc_fbk.sv
module olmc_fbk
  import olmc_pkg::*;
(
  input  path_e  path,
  input  logic   q,
  input  drive_t drv,
  input  logic   pin_in,
  output logic   fb_t,
  output logic   fb_c
);

  logic pad_level;

  always_comb begin
    pad_level = drv.enable ? drv.level : pin_in;
    if (path == PATH_CLOCKED)
      fb_t = ~q;
    else
      fb_t = pad_level;
    fb_c = ~fb_t;
  end

endmodule

// File: rtl/olmc_bank.sv
module olmc_bank
  import olmc_pkg::*;
#(
  parameter int CELLS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] cfg_pol,
  input  logic [CELLS-1:0] cfg_comb,
  input  logic [CELLS-1:0] sum_in,
  input  logic [CELLS-1:0] oe_term,
  input  logic             ar_term,
  input  logic             sp_term,
  input  logic             pl_en,
  input  logic [CELLS-1:0] pl_val,
  input  logic [CELLS-1:0] pin_in,
  output logic [CELLS-1:0] pin_out,
  output logic [CELLS-1:0] pin_oe,
  output logic [CELLS-1:0] fb_true,
  output logic [CELLS-1:0] fb_comp
);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    path_e  path;
    logic   q;
    drive_t drv;

    assign path = cfg_comb[c] ? PATH_DIRECT : PATH_CLOCKED;

    olmc_store u_store (
      .clk       (clk),
      .rst       (rst),
      .clr_async (ar_term),
      .set_sync  (sp_term),
      .ld_en     (pl_en),
      .ld_val    (pl_val[c]),
      .d         (sum_in[c]),
      .q         (q)
    );

    olmc_drive u_drive (
      .path    (path),
      .pol_hi  (cfg_pol[c]),
      .q       (q),
      .sum     (sum_in[c]),
      .oe_term (oe_term[c]),
      .drv     (drv)
    );

    olmc_fbk u_fbk (
      .path   (path),
      .q      (q),
      .drv    (drv),
      .pin_in (pin_in[c]),
      .fb_t   (fb_true[c]),
      .fb_c   (fb_comp[c])
    );

    assign pin_out[c] = drv.level;
    assign pin_oe[c]  = drv.enable;
  end

endmodule

// File: rtl/olmc_bank_chk.sv
module olmc_bank_chk #(
  parameter int CELLS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [CELLS-1:0] cfg_pol,
  input logic [CELLS-1:0] cfg_comb,
  input logic [CELLS-1:0] oe_term,
  input logic             ar_term,
  input logic             sp_term,
  input logic             pl_en,
  input logic [CELLS-1:0] pl_val,
  input logic [CELLS-1:0] pin_in,
  input logic [CELLS-1:0] pin_out,
  input logic [CELLS-1:0] fb_true,
  input logic [CELLS-1:0] fb_comp
);

  for (genvar c = 0; c < CELLS; c++) begin : g_chk
    // R1
    reg_pol_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_comb[c] && cfg_pol[c]) |-> (pin_out[c] == fb_comp[c]));

    // R6
    async_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (ar_term && !cfg_comb[c]) |-> !fb_comp[c]);

    // R4
    comb_in_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_comb[c] && !oe_term[c]) |-> (fb_true[c] == pin_in[c]));

    // R7
    preset_chk: assert property (@(posedge clk) disable iff (rst)
      (sp_term && !pl_en && !ar_term) |=> (ar_term || cfg_comb[c] || fb_comp[c]));

    // R10
    preload_chk: assert property (@(posedge clk) disable iff (rst)
      (pl_en && !ar_term) |=> (ar_term || cfg_comb[c] || (fb_comp[c] == $past(pl_val[c]))));
  end

endmodule

bind olmc_bank olmc_bank_chk #(.CELLS(CELLS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_pol  (cfg_pol),
  .cfg_comb (cfg_comb),
  .oe_term  (oe_term),
  .ar_term  (ar_term),
  .sp_term  (sp_term),
  .pl_en    (pl_en),
  .pl_val   (pl_val),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .fb_true  (fb_true),
  .fb_comp  (fb_comp)
);

// File: tb/olmc_bank_tb.sv
module olmc_bank_tb;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pol = '1, comb = '0, sum = '0, oe = '1, plv = '0, pin_in = '0;
  logic         ar = 1'b0, sp = 1'b0, pl = 1'b0;
  logic [N-1:0] pin_out, pin_oe, fb_true, fb_comp;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mq = '0;

  typedef struct {
    logic [N-1:0] po, oe, ft, fc;
    string        tag;
  } exp_t;
  exp_t sb[$];
  exp_t mon_e;

  always #5 clk = ~clk;

  olmc_bank #(.CELLS(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_pol(pol), .cfg_comb(comb), .sum_in(sum),
    .oe_term(oe), .ar_term(ar), .sp_term(sp), .pl_en(pl), .pl_val(plv),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .fb_true(fb_true), .fb_comp(fb_comp)
  );

  function automatic exp_t expect_of(logic [N-1:0] q, string tag);
    exp_t e;
    for (int i = 0; i < N; i++) begin
      logic raw, side;
      raw     = comb[i] ? sum[i] : q[i];
      e.po[i] = pol[i] ? raw : ~raw;
      e.oe[i] = oe[i];
      side    = oe[i] ? e.po[i] : pin_in[i];
      e.ft[i] = comb[i] ? side : ~q[i];
      e.fc[i] = ~e.ft[i];
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (pin_out !== e.po || pin_oe !== e.oe || fb_true !== e.ft || fb_comp !== e.fc) begin
      errors++;
      $display("FAIL %s: got out=%h oe=%h ft=%h fc=%h expected out=%h oe=%h ft=%h fc=%h",
               e.tag, pin_out, pin_oe, fb_true, fb_comp, e.po, e.oe, e.ft, e.fc);
    end
  endtask

  // driver: model the edge, queue the expectation, let the edge happen
  task automatic cycle(string tag);
    if (ar)       mq = '0;
    else if (rst) mq = '0;
    else if (pl)  mq = plv;
    else if (sp)  mq = '1;
    else          mq = sum;
    sb.push_back(expect_of(mq, tag));
    @(posedge clk);
    @(negedge clk);
  endtask

  // check without a clock edge (combinational or asynchronous effects)
  task automatic now_check(string tag);
    if (ar) mq = '0;
    #1;
    compare(expect_of(mq, tag));
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      mon_e = sb.pop_front();
      compare(mon_e);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    pol = 2'b01; sum = 2'b11; pl = 1'b1; plv = 2'b11; sp = 1'b1;
    cycle("R11 reset overrides preload/set, R12 active-low pin high");
    rst = 1'b0; pl = 1'b0; sp = 1'b0;

    sum = 2'b10;
    cycle("R1 clocked capture of sum, mixed polarity");
    sum = 2'b01; pol = 2'b11;
    cycle("R1 clocked capture, active high");
    pin_in = 2'b11;
    now_check("R2 clocked feedback ignores pin_in");
    oe = 2'b00;
    now_check("R5 enable off in clocked mode, R2 feedback from register");
    oe = 2'b10;
    now_check("R5 mixed enable");

    comb = 2'b11; oe = 2'b11; sum = 2'b10; pol = 2'b01;
    now_check("R3 direct path mixed polarity, R13 pair");
    sum = 2'b01;
    now_check("R3 direct path follows sum without edge");
    oe = 2'b00; pin_in = 2'b10;
    now_check("R4 disabled cell feeds back pin_in");
    oe = 2'b01; pin_in = 2'b00;
    now_check("R4 mixed enable feedback");

    comb = 2'b00; oe = 2'b11; pol = 2'b11; sum = 2'b11;
    cycle("R1 load ones before clear");
    ar = 1'b1;
    now_check("R6 asynchronous clear before edge");
    cycle("R6 clear held across edge");
    pol = 2'b00;
    now_check("R12 active-low pins high after clear");
    sp = 1'b1;
    cycle("R8 clear beats set");
    ar = 1'b0; sum = 2'b00; pol = 2'b11;
    cycle("R7 set on edge, R9 sum ignored");
    sp = 1'b0;
    cycle("R1 set released, sum captured");
    sp = 1'b1; pl = 1'b1; plv = 2'b01; sum = 2'b10;
    cycle("R10 preload beats set and sum");
    sp = 1'b0; plv = 2'b10; sum = 2'b01;
    cycle("R10 preload beats sum");
    pl = 1'b0; rst = 1'b1; sum = 2'b11;
    cycle("R11 reset clears preloaded state");
    rst = 1'b0;
    cycle("R1 capture after reset release");

    @(posedge clk);
    #4;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule